// File: doc/BRIEF.md
# Twisted-Ring Decade Counter

This block counts from zero to nine in a five-bit Johnson register and drives ten decoded lines. Exactly one line is high at a time. A separate carry line follows the top register bit, inverted. The carry is high for the lower half of the count (zero to four) and low for the upper half (five to nine).

The counter has two count inputs. It steps when the first input rises while the second input is low. It also steps when the second input falls while the first input is high. Both inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and edges are found by comparing the synchronized level with the sample one clock earlier.

A master clear forces count zero at once, without waiting for a clock edge, and holds it there as long as the clear stays high. A synchronous reset also returns the block to count zero. Counters can be chained: the carry of one drives the first count input of the next. The next counter then steps when the carry goes high again at the wrap from nine to zero.

Top module: `johnson_decade`

## Requirements
- R1: Exactly one bit of `dec` is high at all times, and bit k is high when the count is k (bit 0 stands for count zero).
- R2: Each step moves the high `dec` bit from position k to position k+1, and after nine the count wraps to zero. Ten steps therefore return the block to its starting count.
- R3: A low-to-high change of `cnt_a` while `cnt_b` is low advances the count by exactly one.
- R4: A high-to-low change of `cnt_b` while `cnt_a` is high advances the count by exactly one.
- R5: The count is unchanged in four cases: a rise of `cnt_a` while `cnt_b` is high, a fall of `cnt_b` while `cnt_a` is low, a rise of `cnt_b`, and a fall of `cnt_a`.
- R6: When the `cnt_a` rise and the `cnt_b` fall qualify in the same clock cycle, the count advances by one, not two.
- R7: `carry` is high for counts 0 to 4 and low for counts 5 to 9.
- R8: While `clr` is high, the count is zero (`dec` = 0000000001, `carry` = 1). This takes effect before the next clock edge and ignores any activity on `cnt_a` and `cnt_b`.
- R9: `rst` sampled high at a rising clock edge sets the count to zero.
- R10: After a qualifying input change, the new count appears after the third rising clock edge, and not after the second.
- R11: When one counter's `carry` drives the `cnt_a` of a second counter whose `cnt_b` is held low, the second counter advances once each time the first wraps from nine to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples both count inputs |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Asynchronous master clear to count zero, active high |
| cnt_a | input | 1 | Count input acting on its rising edge, gated by `cnt_b` low |
| cnt_b | input | 1 | Count input acting on its falling edge, gated by `cnt_a` high |
| dec | output | 10 | One-hot decoded count |
| carry | output | 1 | Inverted top register bit; low for counts 5 to 9 |

## Verification
Two functions can land on the same clock cycle: the `cnt_a` rising-edge advance and the `cnt_b` falling-edge advance. The bench provokes this by parking `cnt_a` low and `cnt_b` high, then flipping both inputs at one falling clock edge. Both synchronized changes then reach the edge detector together. The result is judged by requiring the one-hot output to move by exactly one position, three clock edges later.

// File: rtl/johnson_decade_pkg.sv
package johnson_decade_pkg;

    localparam int unsigned MAX_STAGES = 16;

    typedef logic [MAX_STAGES-1:0] wide_t;

    typedef struct packed {
        logic lvl_a;
        logic lvl_b;
    } pins_t;

    typedef struct packed {
        logic rise_a;
        logic fall_b;
    } hit_t;

    // number of places where neighbouring bits differ (open chain, not circular)
    function automatic int unsigned seam_count(wide_t v, int unsigned n);
        int unsigned c = 0;
        for (int unsigned i = 0; i + 1 < MAX_STAGES; i++) begin
            if ((i + 1 < n) && (v[i] != v[i+1])) c++;
        end
        return c;
    endfunction

    // one twisted-ring step; any pattern with more than one seam restarts at zero
    function automatic wide_t johnson_step(wide_t v, int unsigned n);
        wide_t r = '0;
        if (seam_count(v, n) > 1) return '0;
        for (int unsigned i = 1; i < MAX_STAGES; i++) begin
            if (i < n) r[i] = v[i-1];
        end
        r[0] = ~v[n-1];
        return r;
    endfunction

endpackage

// File: rtl/johnson_decade_edge.sv
module johnson_decade_edge
    import johnson_decade_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins_in,
    output hit_t  hits,
    output logic  adv
);

    localparam int unsigned TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_a;
    logic [SYNC_STAGES-1:0] sync_b;
    logic                   prev_a;
    logic                   prev_b;
    logic                   now_a;
    logic                   now_b;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_a <= '0;
                    sync_b <= '0;
                end else begin
                    sync_a <= pins_in.lvl_a;
                    sync_b <= pins_in.lvl_b;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_a <= '0;
                    sync_b <= '0;
                end else begin
                    sync_a <= {sync_a[SYNC_STAGES-2:0], pins_in.lvl_a};
                    sync_b <= {sync_b[SYNC_STAGES-2:0], pins_in.lvl_b};
                end
            end
        end
    endgenerate

    assign now_a = sync_a[TOP];
    assign now_b = sync_b[TOP];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_a <= 1'b0;
            prev_b <= 1'b0;
        end else begin
            prev_a <= now_a;
            prev_b <= now_b;
        end
    end

    always_comb begin
        hits.rise_a = now_a & ~prev_a & ~now_b;
        hits.fall_b = ~now_b & prev_b & now_a;
        adv         = hits.rise_a | hits.fall_b;
    end

    // R6: a qualified edge never yields two advances in a row
    p_adv_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        adv |=> !adv);

    // R5: with the second input steadily high nothing can advance the count
    p_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (now_b && prev_b) |-> !adv);

endmodule

// File: rtl/johnson_decade_ring.sv
module johnson_decade_ring
    import johnson_decade_pkg::*;
#(
    parameter int unsigned STAGES = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              adv,
    output logic [STAGES-1:0] bits
);

    wide_t nxt;

    always_comb begin
        nxt = johnson_step(wide_t'(bits), STAGES);
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            bits <= '0;
        end else if (rst) begin
            bits <= '0;
        end else if (adv) begin
            bits <= nxt[STAGES-1:0];
        end
    end

    // R2: the register only ever holds one of the legal twisted-ring codes
    p_legal_r2: assert property (@(posedge clk) disable iff (rst)
        seam_count(wide_t'(bits), STAGES) <= 1);

    // R8: master clear pins the register at zero
    p_clr_r8: assert property (@(posedge clk) disable iff (rst)
        clr |-> (bits == '0));

endmodule

// File: rtl/johnson_decade_decode.sv
module johnson_decade_decode #(
    parameter int unsigned STAGES = 5,
    localparam int unsigned STATES = 2 * STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] bits,
    output logic [STATES-1:0] dec
);

    localparam int unsigned MSB = STAGES - 1;

    // each state is picked out by one adjacent pair of register bits
    generate
        for (genvar k = 0; k < STATES; k++) begin : g_line
            if (k == 0) begin : g_zero
                assign dec[k] = ~bits[MSB] & ~bits[0];
            end else if (k < STAGES) begin : g_fill
                assign dec[k] = bits[k-1] & ~bits[k];
            end else if (k == STAGES) begin : g_full
                assign dec[k] = bits[MSB] & bits[0];
            end else begin : g_drain
                assign dec[k] = ~bits[k-STAGES-1] & bits[k-STAGES];
            end
        end
    endgenerate

    // R1: exactly one decoded line is high
    p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(dec) == 1);

endmodule

// File: rtl/johnson_decade.sv
module johnson_decade
    import johnson_decade_pkg::*;
#(
    parameter int unsigned STAGES      = 5,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned STATES     = 2 * STAGES,
    localparam int unsigned HALF       = STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              cnt_a,
    input  logic              cnt_b,
    output logic [STATES-1:0] dec,
    output logic              carry
);

    pins_t             pins;
    hit_t              hits;
    logic              adv;
    logic [STAGES-1:0] bits;

    assign pins.lvl_a = cnt_a;
    assign pins.lvl_b = cnt_b;

    johnson_decade_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst    (rst),
        .pins_in(pins),
        .hits   (hits),
        .adv    (adv)
    );

    johnson_decade_ring #(
        .STAGES(STAGES)
    ) u_ring (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .adv (adv),
        .bits(bits)
    );

    johnson_decade_decode #(
        .STAGES(STAGES)
    ) u_decode (
        .clk (clk),
        .rst (rst),
        .bits(bits),
        .dec (dec)
    );

    assign carry = ~bits[STAGES-1];

    // R2: an advance rotates the one-hot output by one place
    p_step_r2: assert property (@(posedge clk) disable iff (rst || clr)
        adv |=> dec == {$past(dec[STATES-2:0]), $past(dec[STATES-1])});

    // R5: without an advance the output holds
    p_hold_r5: assert property (@(posedge clk) disable iff (rst || clr)
        !adv |=> $stable(dec));

    // R7: carry is high exactly in the lower half of the count
    p_carry_r7: assert property (@(posedge clk) disable iff (rst)
        carry == (dec[HALF-1:0] != '0));

endmodule

// File: tb/johnson_decade_bench.sv
module johnson_decade_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b1;
    logic       cnt_a = 1'b0;
    logic       cnt_b = 1'b0;
    logic [9:0] dec;
    logic       carry;
    logic [9:0] dec_hi;
    logic       carry_hi;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_lo   = 0;
    int exp_hi   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    johnson_decade u_johnson_decade (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .cnt_a(cnt_a),
        .cnt_b(cnt_b),
        .dec  (dec),
        .carry(carry)
    );

    johnson_decade u_johnson_decade_hi (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .cnt_a(carry),
        .cnt_b(1'b0),
        .dec  (dec_hi),
        .carry(carry_hi)
    );

    task automatic check_val(input string tag, input logic [9:0] got_d, input logic got_c, input int e);
        logic [9:0] want_d;
        logic       want_c;
        want_d = 10'd1 << e;
        want_c = (e < 5);
        n_checks++;
        if (got_d !== want_d || got_c !== want_c) begin
            n_fail++;
            $display("FAIL %s: dec=%b carry=%b expected dec=%b carry=%b",
                     tag, got_d, got_c, want_d, want_c);
        end
    endtask

    task automatic bump_lo();
        if (exp_lo == 9) begin
            exp_lo = 0;
            exp_hi = (exp_hi + 1) % 10;
        end else begin
            exp_lo = exp_lo + 1;
        end
    endtask

    // drive levels at a falling edge, wait three rising edges, then judge
    task automatic apply(input string tag, input logic a, input logic b, input bit steps);
        @(negedge clk);
        cnt_a = a;
        cnt_b = b;
        repeat (3) @(negedge clk);
        if (steps) bump_lo();
        check_val(tag, dec, carry, exp_lo);
    endtask

    task automatic t_reset_state();
        check_val("R9 reset state", dec, carry, 0);
        check_val("R9 reset state (chained)", dec_hi, carry_hi, 0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        cnt_a = 1'b1;
        repeat (2) @(negedge clk);
        check_val("R10 not yet after two edges", dec, carry, exp_lo);
        @(negedge clk);
        bump_lo();
        check_val("R10 advanced after third edge", dec, carry, exp_lo);
        apply("R5 fall of cnt_a ignored", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_rise_run();
        for (int i = 0; i < 12; i++) begin
            apply("R3 R1 R7 R2 rise of cnt_a", 1'b1, 1'b0, 1'b1);
            apply("R5 fall of cnt_a ignored", 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic t_fall_b();
        for (int i = 0; i < 3; i++) begin
            apply("R5 rise of cnt_b ignored", 1'b0, 1'b1, 1'b0);
            apply("R5 rise of cnt_a with cnt_b high ignored", 1'b1, 1'b1, 1'b0);
            apply("R4 fall of cnt_b with cnt_a high", 1'b1, 1'b0, 1'b1);
            apply("R5 fall of cnt_a ignored", 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic t_ignored();
        apply("R5 rise of cnt_b ignored", 1'b0, 1'b1, 1'b0);
        apply("R5 fall of cnt_b with cnt_a low ignored", 1'b0, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        check_val("R5 idle levels hold", dec, carry, exp_lo);
    endtask

    task automatic t_both();
        for (int i = 0; i < 2; i++) begin
            apply("R5 rise of cnt_b ignored", 1'b0, 1'b1, 1'b0);
            apply("R6 both conditions in one cycle", 1'b1, 1'b0, 1'b1);
            apply("R5 fall of cnt_a ignored", 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic t_cascade();
        int start_hi;
        start_hi = exp_hi;
        while (exp_hi == start_hi) begin
            apply("R3 drive toward wrap", 1'b1, 1'b0, 1'b1);
            apply("R5 fall of cnt_a ignored", 1'b0, 1'b0, 1'b0);
        end
        repeat (4) @(negedge clk);
        check_val("R11 chained counter after wrap", dec_hi, carry_hi, exp_hi);
    endtask

    task automatic t_clear();
        apply("R3 move off zero", 1'b1, 1'b0, 1'b1);
        apply("R5 fall of cnt_a ignored", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        clr = 1'b1;
        #1;
        exp_lo = 0;
        exp_hi = 0;
        check_val("R8 clear acts before a clock edge", dec, carry, 0);
        cnt_a = 1'b1;
        repeat (4) @(negedge clk);
        check_val("R8 edges ignored under clear", dec, carry, 0);
        cnt_a = 1'b0;
        cnt_b = 1'b1;
        repeat (4) @(negedge clk);
        cnt_a = 1'b1;
        cnt_b = 1'b0;
        repeat (4) @(negedge clk);
        check_val("R8 both edges ignored under clear", dec, carry, 0);
        cnt_a = 1'b0;
        repeat (4) @(negedge clk);
        clr = 1'b0;
        repeat (4) @(negedge clk);
        check_val("R8 zero after clear release", dec, carry, 0);
        check_val("R8 chained counter cleared", dec_hi, carry_hi, 0);
    endtask

    task automatic t_sync_reset();
        for (int i = 0; i < 6; i++) begin
            apply("R3 climb before reset", 1'b1, 1'b0, 1'b1);
            apply("R5 fall of cnt_a ignored", 1'b0, 1'b0, 1'b0);
        end
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_lo = 0;
        check_val("R9 synchronous reset", dec, carry, 0);
        repeat (4) @(negedge clk);
        check_val("R9 stays at zero after reset", dec, carry, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        clr = 1'b0;
        repeat (3) @(negedge clk);
        t_reset_state();
        t_latency();
        t_rise_run();
        t_fall_b();
        t_ignored();
        t_both();
        t_cascade();
        t_clear();
        t_sync_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule